// File: doc/BRIEF.md
# Stop-Clock Throttle Controller

This block is a power-management sequencer. It drives an active-low stop request to a processor. Software programs two 8-bit registers. The control register holds the stop-request mode, the throttle enable, the automatic-throttle enable, the PCI clock stop enable and the standby resolution. The duration register holds how many 32 µs timebase ticks each asserted period lasts. The block counts a single-cycle timebase enable, `base_tick`, which arrives every 32 µs.

There are two ways to assert the request. First, a one-cycle strobe marks a software read of the power-management command port. When the mode field is active, that strobe starts one asserted period. Second, with throttling enabled and the mode active, the block loops on its own. It asserts for the programmed count, then releases for a fixed number of ticks given by a parameter, then asserts again. It also divides the timebase into a standby tick of 4 ms or 32 ms.

The sequencer has four named states:
- `ST_IDLE`: output high.
- `ST_CMD_LOW`: output low, started by a command-port read.
- `ST_THR_LOW`: output low, a throttle period.
- `ST_THR_GAP`: output high, the gap between throttle periods.

The state transitions are named as follows:
- `ST_IDLE` to `ST_THR_LOW` when throttling runs (throttle enable set and mode active).
- `ST_IDLE` to `ST_CMD_LOW` on a command strobe while the mode is active and throttling does not run.
- `ST_CMD_LOW` to `ST_IDLE` when the count expires or the mode becomes inactive.
- `ST_THR_LOW` to `ST_THR_GAP` when the count expires.
- `ST_THR_GAP` to `ST_THR_LOW` when the gap expires; the count is reloaded.
- `ST_THR_LOW` or `ST_THR_GAP` to `ST_IDLE` as soon as throttling stops running.

Top module: `clk_stop_throttle`

## Requirements
- R1: After reset, both registers read 00h, `cpu_stop_n` is 1 and `standby_tick` is 0.
- R2: A write with `reg_wr_sel`=0 stores the control bits and they read back on the next cycle. The bits are: bit 0 PCI clock stop enable, bit 1 throttle enable, bits 3:2 mode, bit 4 auto-throttle enable, bit 7 standby resolution. Bits 6:5 are ignored and always read 0. `reg_wr_sel`=1 writes the duration register.
- R3: With mode 00 (disabled) or 11 (reserved, same as 00), `cmd_rd_strobe` has no effect and `cpu_stop_n` stays 1.
- R4: With mode 01 (stop-grant) or 10 (stop-clock) and throttling off, a `cmd_rd_strobe` drives `cpu_stop_n` low on the clock edge that samples it.
- R5: The duration value N is loaded when the output falls. The output then stays low for exactly N `base_tick` pulses, for N from 1 to 255.
- R6: A duration of 00h is treated as 1, so the output is low for one tick.
- R7: With throttle enable set and mode 01 or 10, the output alternates: low for N ticks, then high for GAP_TICKS ticks (default 4), repeating.
- R8: If a write clears the throttle enable or sets the mode to 00/11, `cpu_stop_n` is high by the second clock edge after the write is presented, and the count is discarded. The next assertion starts from the full duration.
- R9: `standby_tick` pulses once per 125 `base_tick` pulses when bit 7 is 0 (4 ms) and once per 1000 when bit 7 is 1 (32 ms).
- R10: Command strobes that arrive while an asserted period runs neither restart nor extend it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write enable |
| reg_wr_sel | input | 1 | 0 = control register, 1 = duration register |
| reg_wr_data | input | 8 | Write data |
| cmd_rd_strobe | input | 1 | One-cycle marker of a command-port read |
| base_tick | input | 1 | One-cycle 32 µs timebase enable |
| ctrl_q | output | 8 | Control register readback |
| dur_q | output | 8 | Duration register readback |
| cpu_stop_n | output | 1 | Active-low stop request to the processor |
| standby_tick | output | 1 | One-cycle standby timebase pulse |

## Verification
Each result has a fixed latency, and every check is placed at that cycle:
- A register write appears on the readback one edge after it is presented.
- A command strobe pulls `cpu_stop_n` low at the edge that samples it.
- A disabling write is seen by the sequencer one edge later, so the output is high at the second edge.
- `standby_tick` is registered, so it rises one edge after the terminal timebase pulse.

The bench drives `base_tick` 2 ns after the rising edge and samples at the falling edge. Pulse widths are therefore measured in timebase pulses seen while the output is low or high. This makes the result independent of where the tick phase falls.

// File: rtl/cst_pkg.sv
package cst_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_CMD_LOW = 2'd1,
        ST_THR_LOW = 2'd2,
        ST_THR_GAP = 2'd3
    } cst_state_e;

    localparam int REG_W        = 8;
    localparam int BIT_PCI_STOP = 0;
    localparam int BIT_THR_EN   = 1;
    localparam int BIT_MODE_LO  = 2;
    localparam int BIT_MODE_HI  = 3;
    localparam int BIT_AUTO_THR = 4;
    localparam int BIT_SBY_RES  = 7;
    localparam logic [REG_W-1:0] CTRL_KEEP_MASK = 8'b1001_1111;

    function automatic logic mode_active(input logic [1:0] mode);
        return (mode == 2'b01) || (mode == 2'b10);
    endfunction
endpackage

// File: rtl/cst_csr.sv
module cst_csr
    import cst_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] ctrl_q,
    output logic [REG_W-1:0] dur_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            dur_q  <= '0;
        end else if (wr_en) begin
            if (wr_sel) dur_q  <= wr_data;
            else        ctrl_q <= wr_data & CTRL_KEEP_MASK;
        end
    end
endmodule

// File: rtl/cst_standby_div.sv
module cst_standby_div #(
    parameter int SHORT_DIV = 125,
    parameter int LONG_DIV  = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic base_tick,
    input  logic long_sel,
    output logic sby_tick
);
    localparam int MAX_DIV = (LONG_DIV > SHORT_DIV) ? LONG_DIV : SHORT_DIV;
    localparam int CW      = $clog2(MAX_DIV);
    localparam logic [CW-1:0] SHORT_LIM = CW'(SHORT_DIV - 1);
    localparam logic [CW-1:0] LONG_LIM  = CW'(LONG_DIV - 1);

    logic [CW-1:0] div_cnt;
    logic [CW-1:0] limit;

    assign limit = long_sel ? LONG_LIM : SHORT_LIM;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_cnt  <= '0;
            sby_tick <= 1'b0;
        end else begin
            sby_tick <= 1'b0;
            if (base_tick) begin
                if (div_cnt >= limit) begin
                    div_cnt  <= '0;
                    sby_tick <= 1'b1;
                end else begin
                    div_cnt <= div_cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/cst_seq_fsm.sv
module cst_seq_fsm
    import cst_pkg::*;
#(
    parameter int CNT_W     = 8,
    parameter int GAP_TICKS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_act,
    input  logic             thr_en,
    input  logic             cmd_rd,
    input  logic             base_tick,
    input  logic [CNT_W-1:0] dur,
    output logic             stop_n,
    output cst_state_e       state,
    output logic [CNT_W-1:0] low_cnt
);
    localparam int GAP_W = $clog2(GAP_TICKS + 1);
    localparam logic [GAP_W-1:0] GAP_LOAD = GAP_W'(GAP_TICKS);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    cst_state_e       state_nx;
    logic [CNT_W-1:0] low_nx;
    logic [GAP_W-1:0] gap_cnt, gap_nx;
    logic [CNT_W-1:0] dur_eff;
    logic             thr_run;

    assign dur_eff = (dur == '0) ? CNT_ONE : dur;
    assign thr_run = mode_act && thr_en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            low_cnt <= '0;
            gap_cnt <= '0;
        end else begin
            state   <= state_nx;
            low_cnt <= low_nx;
            gap_cnt <= gap_nx;
        end
    end

    always_comb begin
        state_nx = state;
        low_nx   = low_cnt;
        gap_nx   = gap_cnt;
        unique case (state)
            ST_IDLE: begin
                if (thr_run) begin
                    state_nx = ST_THR_LOW;
                    low_nx   = dur_eff;
                end else if (mode_act && cmd_rd) begin
                    state_nx = ST_CMD_LOW;
                    low_nx   = dur_eff;
                end
            end
            ST_CMD_LOW: begin
                if (!mode_act) begin
                    state_nx = ST_IDLE;
                    low_nx   = '0;
                end else if (base_tick) begin
                    if (low_cnt == CNT_ONE) begin
                        state_nx = ST_IDLE;
                        low_nx   = '0;
                    end else begin
                        low_nx = low_cnt - 1'b1;
                    end
                end
            end
            ST_THR_LOW: begin
                if (!thr_run) begin
                    state_nx = ST_IDLE;
                    low_nx   = '0;
                end else if (base_tick) begin
                    if (low_cnt == CNT_ONE) begin
                        state_nx = ST_THR_GAP;
                        low_nx   = '0;
                        gap_nx   = GAP_LOAD;
                    end else begin
                        low_nx = low_cnt - 1'b1;
                    end
                end
            end
            ST_THR_GAP: begin
                if (!thr_run) begin
                    state_nx = ST_IDLE;
                    gap_nx   = '0;
                end else if (base_tick) begin
                    if (gap_cnt <= GAP_W'(1)) begin
                        state_nx = ST_THR_LOW;
                        low_nx   = dur_eff;
                        gap_nx   = '0;
                    end else begin
                        gap_nx = gap_cnt - 1'b1;
                    end
                end
            end
            default: begin
                state_nx = ST_IDLE;
                low_nx   = '0;
                gap_nx   = '0;
            end
        endcase
    end

    always_comb begin
        unique case (state)
            ST_CMD_LOW, ST_THR_LOW: stop_n = 1'b0;
            default:                stop_n = 1'b1;
        endcase
    end
endmodule

// File: rtl/clk_stop_throttle.sv
module clk_stop_throttle
    import cst_pkg::*;
#(
    parameter int GAP_TICKS     = 4,
    parameter int SBY_SHORT_DIV = 125,
    parameter int SBY_LONG_DIV  = 1000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_wr_en,
    input  logic       reg_wr_sel,
    input  logic [7:0] reg_wr_data,
    input  logic       cmd_rd_strobe,
    input  logic       base_tick,
    output logic [7:0] ctrl_q,
    output logic [7:0] dur_q,
    output logic       cpu_stop_n,
    output logic       standby_tick
);
    cst_state_e fsm_state;
    logic [7:0] low_cnt;
    logic       mode_act;

    cst_csr u_csr (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr_en),
        .wr_sel  (reg_wr_sel),
        .wr_data (reg_wr_data),
        .ctrl_q  (ctrl_q),
        .dur_q   (dur_q)
    );

    assign mode_act = mode_active(ctrl_q[BIT_MODE_HI:BIT_MODE_LO]);

    cst_seq_fsm #(
        .CNT_W     (REG_W),
        .GAP_TICKS (GAP_TICKS)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_act  (mode_act),
        .thr_en    (ctrl_q[BIT_THR_EN]),
        .cmd_rd    (cmd_rd_strobe),
        .base_tick (base_tick),
        .dur       (dur_q),
        .stop_n    (cpu_stop_n),
        .state     (fsm_state),
        .low_cnt   (low_cnt)
    );

    cst_standby_div #(
        .SHORT_DIV (SBY_SHORT_DIV),
        .LONG_DIV  (SBY_LONG_DIV)
    ) u_sby (
        .clk       (clk),
        .rst_n     (rst_n),
        .base_tick (base_tick),
        .long_sel  (ctrl_q[BIT_SBY_RES]),
        .sby_tick  (standby_tick)
    );
endmodule

// File: rtl/clk_stop_throttle_chk.sv
module clk_stop_throttle_chk
    import cst_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] ctrl_q,
    input logic [7:0] dur_q,
    input logic       cpu_stop_n,
    input logic       standby_tick,
    input cst_state_e state,
    input logic [7:0] low_cnt
);
    logic chk_mode_act;
    assign chk_mode_act = (ctrl_q[3:2] == 2'b01) || (ctrl_q[3:2] == 2'b10);

    // R2: reserved control bits never hold a 1
    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q[6:5] == 2'b00);

    // R3: an inactive mode leaves the output high on the next cycle
    a_r3_inactive_high: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_mode_act |=> cpu_stop_n);

    // R5: the falling edge coincides with a load of the duration
    a_r5_load_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cpu_stop_n) |->
            low_cnt == (($past(dur_q) == 8'd0) ? 8'd1 : $past(dur_q)));

    // R6: an asserted period never runs with an empty count
    a_r6_cnt_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_stop_n |-> low_cnt != 8'd0);

    // R8: throttle states are left once the enable is clear
    a_r8_thr_off: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q[1] |=> !((state == ST_THR_LOW) || (state == ST_THR_GAP)));

    // R9: standby pulse lasts one cycle
    a_r9_sby_single: assert property (@(posedge clk) disable iff (!rst_n)
        standby_tick |=> !standby_tick);
endmodule

bind clk_stop_throttle clk_stop_throttle_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ctrl_q       (ctrl_q),
    .dur_q        (dur_q),
    .cpu_stop_n   (cpu_stop_n),
    .standby_tick (standby_tick),
    .state        (fsm_state),
    .low_cnt      (low_cnt)
);

// File: tb/clk_stop_throttle_tb.sv
`timescale 1ns/1ps
module clk_stop_throttle_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr_en = 1'b0;
    logic       reg_wr_sel = 1'b0;
    logic [7:0] reg_wr_data = 8'h00;
    logic       cmd_rd_strobe = 1'b0;
    logic       base_tick = 1'b0;
    logic [7:0] ctrl_q, dur_q;
    logic       cpu_stop_n, standby_tick;

    int checks = 0;
    int errors = 0;
    int tick_mode = 0;   // 0 none, 1 every 4 cycles, 2 every cycle
    int tick_phase = 0;

    always #5 clk = ~clk;

    clk_stop_throttle u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .reg_wr_en     (reg_wr_en),
        .reg_wr_sel    (reg_wr_sel),
        .reg_wr_data   (reg_wr_data),
        .cmd_rd_strobe (cmd_rd_strobe),
        .base_tick     (base_tick),
        .ctrl_q        (ctrl_q),
        .dur_q         (dur_q),
        .cpu_stop_n    (cpu_stop_n),
        .standby_tick  (standby_tick)
    );

    always begin
        @(posedge clk);
        #2;
        if (tick_mode == 2) base_tick = 1'b1;
        else if (tick_mode == 1) begin
            tick_phase = (tick_phase + 1) % 4;
            base_tick = (tick_phase == 0);
        end else base_tick = 1'b0;
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [7:0] data);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_sel = sel; reg_wr_data = data;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic strobe();
        @(negedge clk);
        cmd_rd_strobe = 1'b1;
        @(negedge clk);
        cmd_rd_strobe = 1'b0;
    endtask

    task automatic wait_level(input logic lvl, output int ok);
        ok = 0;
        for (int i = 0; i < 3000; i++) begin
            if (cpu_stop_n == lvl) begin ok = 1; break; end
            @(negedge clk);
        end
    endtask

    // counts ticks seen while output is at lvl, until it leaves lvl
    task automatic count_ticks(input logic lvl, input logic poke, output int n);
        int ok;
        n = 0;
        wait_level(lvl, ok);
        for (int i = 0; i < 3000 && ok == 1; i++) begin
            if (cpu_stop_n != lvl) break;
            if (base_tick) n++;
            cmd_rd_strobe = poke;
            @(negedge clk);
        end
        cmd_rd_strobe = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 ctrl reset", ctrl_q, 0);
        check("R1 dur reset", dur_q, 0);
        check("R1 stop_n reset", cpu_stop_n, 1);
        check("R1 standby reset", standby_tick, 0);
    endtask

    task automatic t_regs();
        wr(1'b0, 8'hF3);
        check("R2 ctrl mask F3", ctrl_q, 8'h93);
        wr(1'b0, 8'h00);
        wr(1'b1, 8'h5A);
        check("R2 dur write", dur_q, 8'h5A);
        check("R2 ctrl untouched", ctrl_q, 8'h00);
    endtask

    task automatic t_inactive();
        int hi = 1;
        wr(1'b1, 8'd3);
        tick_mode = 1;
        wr(1'b0, 8'h00);
        strobe();
        for (int i = 0; i < 6; i++) begin if (!cpu_stop_n) hi = 0; @(negedge clk); end
        check("R3 mode 00 strobe ignored", hi, 1);
        wr(1'b0, 8'h0C);
        strobe();
        for (int i = 0; i < 6; i++) begin if (!cpu_stop_n) hi = 0; @(negedge clk); end
        check("R3 mode 11 strobe ignored", hi, 1);
    endtask

    task automatic t_cmd_width(input logic [7:0] d, input int exp, input string req);
        int n;
        wr(1'b1, d);
        wr(1'b0, 8'h04);
        @(negedge clk);
        cmd_rd_strobe = 1'b1;
        @(negedge clk);
        cmd_rd_strobe = 1'b0;
        check("R4 low one edge after strobe", cpu_stop_n, 0);
        count_ticks(1'b0, 1'b0, n);
        check(req, n, exp);
    endtask

    task automatic t_no_extend();
        int n;
        wr(1'b1, 8'd5);
        wr(1'b0, 8'h08);
        strobe();
        count_ticks(1'b0, 1'b1, n);
        check("R10 strobes during low ignored", n, 5);
    endtask

    task automatic t_throttle();
        int n;
        wr(1'b1, 8'd3);
        wr(1'b0, 8'h06);
        count_ticks(1'b0, 1'b0, n); check("R7 first low", n, 3);
        count_ticks(1'b1, 1'b0, n); check("R7 first gap", n, 4);
        count_ticks(1'b0, 1'b0, n); check("R7 second low", n, 3);
        count_ticks(1'b1, 1'b0, n); check("R7 second gap", n, 4);
        wr(1'b0, 8'h00);
    endtask

    task automatic t_abort();
        int ok, n;
        wr(1'b1, 8'd20);
        wr(1'b0, 8'h06);
        wait_level(1'b0, ok);
        for (int i = 0; i < 8; i++) @(negedge clk);
        wr(1'b0, 8'h04);
        @(negedge clk);
        check("R8 throttle clear releases", cpu_stop_n, 1);
        for (int i = 0; i < 10; i++) @(negedge clk);
        check("R8 stays released", cpu_stop_n, 1);
        wr(1'b0, 8'h06);
        count_ticks(1'b0, 1'b0, n);
        check("R8 full count after restart", n, 20);
        wr(1'b0, 8'h00);
        wr(1'b0, 8'h08);
        strobe();
        for (int i = 0; i < 8; i++) @(negedge clk);
        wr(1'b0, 8'h00);
        @(negedge clk);
        check("R8 mode 00 releases cmd period", cpu_stop_n, 1);
    endtask

    task automatic t_standby(input logic long_sel, input int exp, input string req);
        int n = 0;
        wr(1'b0, long_sel ? 8'h80 : 8'h00);
        tick_mode = 2;
        for (int p = 0; p < 2; p++) begin
            for (int i = 0; i < 3000; i++) begin
                if (standby_tick) break;
                @(negedge clk);
            end
            @(negedge clk);
        end
        n = 1;
        for (int i = 0; i < 3000; i++) begin
            if (standby_tick) break;
            n++;
            @(negedge clk);
        end
        check(req, n, exp);
        tick_mode = 1;
    endtask

    initial begin
        for (int i = 0; i < 150000; i++) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_regs();
        t_inactive();
        t_cmd_width(8'd1,   1,   "R5 width 1");
        t_cmd_width(8'd2,   2,   "R5 width 2");
        t_cmd_width(8'd255, 255, "R5 width 255");
        t_cmd_width(8'd0,   1,   "R6 zero treated as 1");
        t_no_extend();
        t_throttle();
        t_abort();
        t_standby(1'b0, 125,  "R9 short standby period");
        t_standby(1'b1, 1000, "R9 long standby period");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule